// File: doc/BRIEF.md
# Byte-Granular Front End for Word-Only Register Files

This block lets a byte-addressed I/O port reach register storage that only accepts whole 32-bit words. A request carries a byte address, a size of 1, 2 or 4 bytes and, for a write, write data in its low bytes. The block decodes the address into one of three windows. The first is a core register file of 16 words. The second is a DMA register file of 8 words. The third is a single 32-bit control register, which the block holds itself. The two register files sit outside the block. Each is reached through an index output, a combinational read-data input, a write strobe and a write-data output.

When a write is narrower than a word or sits off word alignment, the block reads the addressed word from the selected file in the same cycle. It substitutes only the addressed byte lanes and writes the whole word back. Read data is moved down from its byte lane and cut to the requested size. A response follows every request exactly one cycle later. An access that falls outside every window, or whose size and offset are not legal, is dropped and answered with an error flag and zero data.

Top module: `subword_access_adapter`

## Requirements
- R1: After reset, `rsp_valid` and `rsp_err` are 0 and `ctrl_value` is 0.
- R2: Byte addresses 0x00 to 0x3F select the core file at word index address/4. Only `core_we` pulses for such a write.
- R3: Byte addresses 0x40 to 0x5F select the DMA file at word index (address-0x40)/4. Only `dma_we` pulses for such a write.
- R4: Byte addresses 0x70 to 0x73 select the internal control word. It reads back through the port, appears on `ctrl_value`, and changes only on a legal write to it.
- R5: Byte order is little-endian. A write of `req_size` bytes at lane `req_addr[1:0]` replaces bytes lane to lane+size-1 of the target word with `req_wdata` bytes 0 to size-1, and leaves all other bytes unchanged. An aligned 4-byte write stores `req_wdata` unchanged.
- R6: A legal read returns the target word shifted right by 8*`req_addr[1:0]`, with every bit at or above 8*`req_size` cleared.
- R7: An access at 0x60 to 0x6F or at 0x74 and above is invalid. It gets `rsp_err`=1 and `rsp_rdata`=0, and it alters no register.
- R8: `req_size` is a binary byte count. Values 0 and 5 to 7 are illegal, as is any access with `req_addr[1:0]`+`req_size` > 4. Such accesses are treated like R7: error, zero data, no write.
- R9: The merge read and the write-back happen in the request's own cycle. Requests on consecutive cycles therefore each see all earlier writes.
- R10: Every request with `req_valid` high gets `rsp_valid` high in the next cycle, together with `rsp_err` and `rsp_rdata`. Write responses carry zero data. Without a request, `rsp_valid` and `rsp_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_size | input | 3 | Byte count, 1 to 4 |
| req_wdata | input | 32 | Write data, low bytes used |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Invalid access flag |
| rsp_rdata | output | 32 | Aligned, masked read data |
| core_idx | output | 4 | Core file word index |
| core_rdata | input | 32 | Core file word at `core_idx` |
| core_we | output | 1 | Core file write strobe |
| core_wdata | output | 32 | Merged word for the core file |
| dma_idx | output | 3 | DMA file word index |
| dma_rdata | input | 32 | DMA file word at `dma_idx` |
| dma_we | output | 1 | DMA file write strobe |
| dma_wdata | output | 32 | Merged word for the DMA file |
| ctrl_value | output | 32 | Current control word |

## Verification
A fault in the lane logic shows up as a neighbouring byte that changes. Such a fault stays hidden until that word is read in full, so the bench reads whole words back after every narrow write. A decode fault writes into the wrong window, or fails to refuse a gap or oversize access. It appears either as a strobe on the same cycle or as a corrupted word on a later read. A fault in the response stage shows one cycle after the request, as a missing or extra `rsp_valid`, or as a stale error flag.

// File: rtl/subword_access_pkg.sv
package subword_access_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_CORE = 2'd1,
      RGN_DMA  = 2'd2,
      RGN_CTRL = 2'd3
   } region_e;

endpackage

// File: rtl/subword_addr_decode.sv
module subword_addr_decode
   import subword_access_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int CORE_BASE  = 'h00,
   parameter int CORE_WORDS = 16,
   parameter int DMA_BASE   = 'h40,
   parameter int DMA_WORDS  = 8,
   parameter int CTRL_ADDR  = 'h70,
   parameter bit CTRL_EN    = 1'b1,
   localparam int BYTES      = DATA_W / 8,
   localparam int LANE_W     = $clog2(BYTES),
   localparam int SIZE_W     = LANE_W + 1,
   localparam int CORE_IDX_W = $clog2(CORE_WORDS),
   localparam int DMA_IDX_W  = $clog2(DMA_WORDS)
) (
   input  logic [ADDR_W-1:0]     addr,
   input  logic [SIZE_W-1:0]     size,
   output region_e               region,
   output logic [CORE_IDX_W-1:0] core_idx,
   output logic [DMA_IDX_W-1:0]  dma_idx,
   output logic [LANE_W-1:0]     lane,
   output logic                  size_ok
);

   localparam int CORE_SPAN = CORE_WORDS * BYTES;
   localparam int DMA_SPAN  = DMA_WORDS * BYTES;
   localparam int CTRL_WORD = CTRL_ADDR / BYTES;

   int   addr_i;
   int   size_i;
   int   lane_i;
   logic hit_core;
   logic hit_dma;
   logic hit_ctrl;

   always_comb begin
      addr_i   = int'(addr);
      size_i   = int'(size);
      lane     = addr[LANE_W-1:0];
      lane_i   = int'(lane);
      hit_core = (addr_i >= CORE_BASE) && (addr_i < CORE_BASE + CORE_SPAN);
      hit_dma  = (addr_i >= DMA_BASE) && (addr_i < DMA_BASE + DMA_SPAN);
      hit_ctrl = CTRL_EN && ((addr_i / BYTES) == CTRL_WORD);
      core_idx = CORE_IDX_W'((addr_i - CORE_BASE) / BYTES);
      dma_idx  = DMA_IDX_W'((addr_i - DMA_BASE) / BYTES);
      size_ok  = (size_i >= 1) && (size_i <= BYTES) && (lane_i + size_i <= BYTES);
      if (hit_core)      region = RGN_CORE;
      else if (hit_dma)  region = RGN_DMA;
      else if (hit_ctrl) region = RGN_CTRL;
      else               region = RGN_NONE;
   end

endmodule

// File: rtl/subword_lane_unit.sv
module subword_lane_unit #(
   parameter int DATA_W = 32,
   localparam int BYTES  = DATA_W / 8,
   localparam int LANE_W = $clog2(BYTES),
   localparam int SIZE_W = LANE_W + 1
) (
   input  logic [DATA_W-1:0] cur_word,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LANE_W-1:0] lane,
   input  logic [SIZE_W-1:0] size,
   output logic [DATA_W-1:0] merged_word,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] wr_shift;
   logic [DATA_W-1:0] rd_shift;
   logic [BYTES-1:0]  lane_en;

   always_comb begin
      wr_shift = wr_data << {lane, 3'b000};
      rd_shift = cur_word >> {lane, 3'b000};
   end

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      always_comb begin
         lane_en[g] = (g >= int'(lane)) && (g < int'(lane) + int'(size));
         merged_word[8*g +: 8] = lane_en[g] ? wr_shift[8*g +: 8] : cur_word[8*g +: 8];
         rd_data[8*g +: 8]     = (g < int'(size)) ? rd_shift[8*g +: 8] : 8'h00;
      end
   end

endmodule

// File: rtl/subword_access_adapter.sv
module subword_access_adapter
   import subword_access_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int CORE_BASE  = 'h00,
   parameter int CORE_WORDS = 16,
   parameter int DMA_BASE   = 'h40,
   parameter int DMA_WORDS  = 8,
   parameter int CTRL_ADDR  = 'h70,
   parameter bit CTRL_EN    = 1'b1,
   localparam int BYTES      = DATA_W / 8,
   localparam int LANE_W     = $clog2(BYTES),
   localparam int SIZE_W     = LANE_W + 1,
   localparam int CORE_IDX_W = $clog2(CORE_WORDS),
   localparam int DMA_IDX_W  = $clog2(DMA_WORDS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic [SIZE_W-1:0]     req_size,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  rsp_valid,
   output logic                  rsp_err,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic [CORE_IDX_W-1:0] core_idx,
   input  logic [DATA_W-1:0]     core_rdata,
   output logic                  core_we,
   output logic [DATA_W-1:0]     core_wdata,
   output logic [DMA_IDX_W-1:0]  dma_idx,
   input  logic [DATA_W-1:0]     dma_rdata,
   output logic                  dma_we,
   output logic [DATA_W-1:0]     dma_wdata,
   output logic [DATA_W-1:0]     ctrl_value
);

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0 || BYTES < 2 || (BYTES & (BYTES - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power-of-two count of bytes, at least two");
   end
   if (CORE_WORDS < 2 || DMA_WORDS < 2) begin : g_bad_depth
      $error("register files need at least two words");
   end
   if (CORE_BASE % BYTES != 0 || DMA_BASE % BYTES != 0 || CTRL_ADDR % BYTES != 0) begin : g_bad_align
      $error("window bases must be word aligned");
   end
   if (CORE_BASE + CORE_WORDS * BYTES > DMA_BASE) begin : g_bad_overlap
      $error("core window must end at or below the DMA window");
   end
   if (CTRL_ADDR + BYTES > (1 << ADDR_W)) begin : g_bad_reach
      $error("control word lies outside the address space");
   end

   region_e           rgn;
   logic [LANE_W-1:0] lane;
   logic              size_ok;
   logic              legal;
   logic              do_write;
   logic              ctrl_we;
   logic [DATA_W-1:0] cur_word;
   logic [DATA_W-1:0] merged_word;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] ctrl_q;

   subword_addr_decode #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CORE_BASE (CORE_BASE),
      .CORE_WORDS(CORE_WORDS),
      .DMA_BASE  (DMA_BASE),
      .DMA_WORDS (DMA_WORDS),
      .CTRL_ADDR (CTRL_ADDR),
      .CTRL_EN   (CTRL_EN)
   ) u_decode (
      .addr    (req_addr),
      .size    (req_size),
      .region  (rgn),
      .core_idx(core_idx),
      .dma_idx (dma_idx),
      .lane    (lane),
      .size_ok (size_ok)
   );

   always_comb begin
      unique case (rgn)
         RGN_CORE: cur_word = core_rdata;
         RGN_DMA:  cur_word = dma_rdata;
         RGN_CTRL: cur_word = ctrl_q;
         default:  cur_word = '0;
      endcase
   end

   subword_lane_unit #(.DATA_W(DATA_W)) u_lanes (
      .cur_word   (cur_word),
      .wr_data    (req_wdata),
      .lane       (lane),
      .size       (req_size),
      .merged_word(merged_word),
      .rd_data    (rd_word)
   );

   always_comb begin
      legal      = size_ok && (rgn != RGN_NONE);
      do_write   = req_valid && req_write && legal;
      core_we    = do_write && (rgn == RGN_CORE);
      dma_we     = do_write && (rgn == RGN_DMA);
      ctrl_we    = do_write && (rgn == RGN_CTRL);
      core_wdata = merged_word;
      dma_wdata  = merged_word;
   end

   if (CTRL_EN) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       ctrl_q <= '0;
         else if (ctrl_we) ctrl_q <= merged_word;
      end
   end else begin : g_no_ctrl
      always_comb ctrl_q = '0;
   end

   assign ctrl_value = ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && !legal;
         rsp_rdata <= (req_valid && !req_write && legal) ? rd_word : '0;
      end
   end

endmodule

// File: rtl/subword_access_chk.sv
module subword_access_chk #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 32,
   parameter int SIZE_W     = 3,
   parameter int LANE_W     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [SIZE_W-1:0] req_size,
   input logic [DATA_W-1:0] req_wdata,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              core_we,
   input logic [DATA_W-1:0] core_wdata,
   input logic              dma_we,
   input logic [DATA_W-1:0] ctrl_value
);

   localparam int BYTES = DATA_W / 8;

   assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_err));

   assert_err_data_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == '0));

   assert_bad_size_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_size == '0 || req_size > SIZE_W'(BYTES)) |-> (!core_we && !dma_we));

   assert_one_file_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({core_we, dma_we}));

   assert_write_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (core_we || dma_we) |-> (req_valid && req_write));

   assert_ctrl_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> $stable(ctrl_value));

   assert_full_word_passes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (core_we && req_size == SIZE_W'(BYTES) && req_addr[LANE_W-1:0] == '0)
         |-> (core_wdata == req_wdata));

endmodule

bind subword_access_adapter subword_access_chk #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .SIZE_W(SIZE_W),
   .LANE_W(LANE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_size  (req_size),
   .req_wdata (req_wdata),
   .rsp_valid (rsp_valid),
   .rsp_err   (rsp_err),
   .rsp_rdata (rsp_rdata),
   .core_we   (core_we),
   .core_wdata(core_wdata),
   .dma_we    (dma_we),
   .ctrl_value(ctrl_value)
);

// File: tb/subword_access_adapter_tb.sv
`timescale 1ns/1ps
module subword_access_adapter_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic        rsp_err;
   logic [31:0] rsp_rdata;
   logic [3:0]  core_idx;
   logic [31:0] core_rdata;
   logic        core_we;
   logic [31:0] core_wdata;
   logic [2:0]  dma_idx;
   logic [31:0] dma_rdata;
   logic        dma_we;
   logic [31:0] dma_wdata;
   logic [31:0] ctrl_value;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   logic [31:0] core_mem [16];
   logic [31:0] dma_mem  [8];
   logic [31:0] ref_core [16];
   logic [31:0] ref_dma  [8];
   logic [31:0] ref_ctrl;

   always #2 clk = ~clk;

   subword_access_adapter u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .core_idx(core_idx), .core_rdata(core_rdata), .core_we(core_we), .core_wdata(core_wdata),
      .dma_idx(dma_idx), .dma_rdata(dma_rdata), .dma_we(dma_we), .dma_wdata(dma_wdata),
      .ctrl_value(ctrl_value)
   );

   // external register files owned by the bench
   assign core_rdata = core_mem[core_idx];
   assign dma_rdata  = dma_mem[dma_idx];
   always @(posedge clk) begin
      if (core_we) core_mem[core_idx] <= core_wdata;
      if (dma_we)  dma_mem[dma_idx]   <= dma_wdata;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // bench reference model, written from the requirements
   task automatic model(input bit wr, input int addr, input int size, input logic [31:0] wd,
                        output logic exp_err, output logic [31:0] exp_data);
      int rgn;
      int lane;
      logic [31:0] w;
      lane = addr % 4;
      if (addr < 'h40) rgn = 1;
      else if (addr < 'h60) rgn = 2;
      else if (addr >= 'h70 && addr < 'h74) rgn = 3;
      else rgn = 0;
      exp_data = '0;
      exp_err  = 1'b0;
      if (rgn == 0 || size < 1 || size > 4 || lane + size > 4) begin
         exp_err = 1'b1;
         return;
      end
      case (rgn)
         1: w = ref_core[addr / 4];
         2: w = ref_dma[(addr - 'h40) / 4];
         default: w = ref_ctrl;
      endcase
      if (wr) begin
         for (int b = 0; b < size; b++) w[8*(lane+b) +: 8] = wd[8*b +: 8];
         case (rgn)
            1: ref_core[addr / 4] = w;
            2: ref_dma[(addr - 'h40) / 4] = w;
            default: ref_ctrl = w;
         endcase
      end else begin
         for (int b = 0; b < 4; b++)
            exp_data[8*b +: 8] = (b < size) ? w[8*(lane+b) +: 8] : 8'h00;
      end
   endtask

   task automatic access(input string tag, input bit wr, input int addr, input int size,
                         input logic [31:0] wd);
      logic        e_err;
      logic [31:0] e_data;
      model(wr, addr, size, wd, e_err, e_data);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = 8'(addr);
      req_size  = 3'(size);
      req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
      check({tag, " rsp_err"},   32'(rsp_err),   32'(e_err));
      check({tag, " rsp_rdata"}, rsp_rdata,      e_data);
   endtask

   task automatic test_reset;
      check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      check("R1 rsp_err after reset", 32'(rsp_err), 32'd0);
      check("R1 ctrl_value after reset", ctrl_value, 32'd0);
   endtask

   task automatic test_windows;
      access("R2 core word 0", 0, 'h00, 4, 0);
      access("R2 core word 15", 0, 'h3C, 4, 0);
      access("R3 dma word 0", 0, 'h40, 4, 0);
      access("R3 dma word 7", 0, 'h5C, 4, 0);
      access("R2 core write word 5", 1, 'h14, 4, 32'hCAFE_F00D);
      access("R2 core readback word 5", 0, 'h14, 4, 0);
      access("R3 dma write word 2", 1, 'h48, 4, 32'h0BAD_BEEF);
      access("R3 dma readback word 2", 0, 'h48, 4, 0);
   endtask

   task automatic test_narrow_reads;
      access("R6 byte lane 1", 0, 'h05, 1, 0);
      access("R6 byte lane 3", 0, 'h43, 1, 0);
      access("R6 half lane 2", 0, 'h26, 2, 0);
      access("R6 half lane 1", 0, 'h51, 2, 0);
   endtask

   task automatic test_merge;
      access("R5 byte write lane 1", 1, 'h09, 1, 32'hFFFF_FFAB);
      access("R5 word after byte write", 0, 'h08, 4, 0);
      access("R5 half write lane 2", 1, 'h4A, 2, 32'h1234_5678);
      access("R5 word after half write", 0, 'h48, 4, 0);
      access("R5 byte write lane 0", 1, 'h3C, 1, 32'h0000_0011);
      access("R5 word after lane 0 write", 0, 'h3C, 4, 0);
   endtask

   task automatic test_ctrl;
      access("R4 ctrl full write", 1, 'h70, 4, 32'hA5A5_1234);
      check("R4 ctrl_value after write", ctrl_value, ref_ctrl);
      access("R4 ctrl half read lane 2", 0, 'h72, 2, 0);
      access("R4 ctrl byte write lane 3", 1, 'h73, 1, 32'h0000_003C);
      check("R4 R5 ctrl_value after byte write", ctrl_value, ref_ctrl);
      access("R4 ctrl read of core leaves ctrl", 0, 'h00, 4, 0);
      check("R4 ctrl_value held", ctrl_value, ref_ctrl);
   endtask

   task automatic test_invalid;
      access("R7 read gap 0x60", 0, 'h60, 4, 0);
      access("R7 write gap 0x64", 1, 'h64, 4, 32'hDEAD_DEAD);
      access("R7 read above ctrl 0x74", 0, 'h74, 4, 0);
      access("R7 write 0xFC", 1, 'hFC, 4, 32'h7777_7777);
      access("R7 dma last word unchanged", 0, 'h5C, 4, 0);
      access("R7 core first word unchanged", 0, 'h00, 4, 0);
      check("R7 ctrl unchanged", ctrl_value, ref_ctrl);
   endtask

   task automatic test_sizes;
      access("R8 size 0 read", 0, 'h04, 0, 0);
      access("R8 size 5 write", 1, 'h04, 5, 32'h1111_1111);
      access("R8 size 7 read", 0, 'h40, 7, 0);
      access("R8 half at lane 3", 1, 'h07, 2, 32'h0000_9999);
      access("R8 word at lane 1", 1, 'h41, 4, 32'h8888_8888);
      access("R8 ctrl word at lane 2", 1, 'h72, 4, 32'h5555_5555);
      access("R8 core word 1 unchanged", 0, 'h04, 4, 0);
      access("R8 dma word 0 unchanged", 0, 'h40, 4, 0);
      check("R8 ctrl unchanged", ctrl_value, ref_ctrl);
   endtask

   task automatic test_back_to_back;
      logic        e0, e1;
      logic [31:0] d0, d1;
      model(1, 'h10, 1, 32'h0000_00C1, e0, d0);
      model(1, 'h11, 1, 32'h0000_00D2, e1, d1);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h10; req_size = 3'd1; req_wdata = 32'hC1;
      @(negedge clk);
      check("R10 first of pair rsp_valid", 32'(rsp_valid), 32'd1);
      check("R10 first of pair rsp_err", 32'(rsp_err), 32'(e0));
      req_addr = 8'h11; req_wdata = 32'hD2;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 second of pair rsp_valid", 32'(rsp_valid), 32'd1);
      check("R10 second of pair rsp_data", rsp_rdata, d1);
      @(negedge clk);
      check("R10 idle rsp_valid", 32'(rsp_valid), 32'd0);
      check("R10 idle rsp_err", 32'(rsp_err), 32'd0);
      access("R9 word after back-to-back writes", 0, 'h10, 4, 0);
      access("R9 neighbour dma write", 1, 'h45, 1, 32'h0000_0077);
      access("R9 neighbour dma readback", 0, 'h44, 4, 0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) begin
         core_mem[i] = 32'h1000_0000 + 32'(i) * 32'h0103_0507;
         ref_core[i] = core_mem[i];
      end
      for (int i = 0; i < 8; i++) begin
         dma_mem[i] = 32'h8000_0000 + 32'(i) * 32'h0211_0913;
         ref_dma[i] = dma_mem[i];
      end
      ref_ctrl = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_windows();
      test_narrow_reads();
      test_merge();
      test_ctrl();
      test_invalid();
      test_sizes();
      test_back_to_back();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule